// File: doc/BRIEF.md
# Packed High-Half Interleave Unit

This unit is one SIMD execution slice. It receives two 64-bit packed operands, a destination and a source, together with an 8-bit opcode. It discards the lower 32 bits of both operands. It then merges the upper halves element by element into a single 64-bit result. The opcode fixes the element width at 8, 16 or 32 bits. In every pair, the destination element takes the less significant slot and the source element sits directly above it.

Operands enter over a valid/ready handshake. The result is held in one output register, with a valid flag and an illegal-opcode flag beside it. The output register keeps its contents for as long as the consumer stalls. While it stalls, the unit refuses new input. When the output drains in the same cycle that a new operation is offered, both happen together, so back-to-back operations run at full rate.

Top module: `hiHalfZip`

## Requirements
- R1: Opcode 0x68 gives byte interleave. From the most significant byte down, the result is {S7,D7,S6,D6,S5,D5,S4,D4}, where Dn and Sn are byte n of the destination and source operands.
- R2: Opcode 0x69 gives 16-bit interleave. From the most significant word down, the result is {S3,D3,S2,D2}.
- R3: Opcode 0x6A gives 32-bit interleave. The result is {S1,D1}, so the destination's upper doubleword lands in result[31:0] and the source's upper doubleword lands in result[63:32].
- R4: Bits 31:0 of both operands never affect the result.
- R5: With an all-zero source, the result is the destination's upper elements zero-extended to twice their width. Bytes become unsigned 16-bit words and words become unsigned 32-bit values.
- R6: Any opcode other than 0x68, 0x69 or 0x6A sets illegalOp together with outValid and yields an all-zero result.
- R7: An operation is accepted at a rising edge where inValid and inReady are both 1. Its result, outValid and illegalOp are visible after that same edge, which is one clock after acceptance.
- R8: While outValid is 1 and outReady is 0, inReady is 0 and result, illegalOp and outValid are held unchanged.
- R9: A synchronous active-high reset clears outValid, illegalOp and result, and leaves inReady at 1.
- R10: An output draining (outReady at 1) in the same cycle that a new operation is accepted replaces the result with the new operation's result at the next edge, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands and opcode are offered |
| inReady | output | 1 | Unit can take an operation this cycle |
| dstOp | input | 64 | Destination packed operand |
| srcOp | input | 64 | Source packed operand |
| opCode | input | 8 | Operation select byte |
| outValid | output | 1 | result holds a finished operation |
| outReady | input | 1 | Consumer takes the result this cycle |
| result | output | 64 | Interleaved packed result |
| illegalOp | output | 1 | Held operation had an unknown opcode |

## Verification
The two functions that can coincide are draining a held result and accepting a new operation. Both fall on the same edge when outReady and inValid are high while outValid is already set. The bench provokes this in two steps. It first stalls the consumer for several cycles with a different operation pending at the input, and checks that the held result and the flags stay fixed and that inReady stays low. It then releases outReady with the pending operation still offered. The check is that exactly one edge later the result equals the pending operation's reference value, with no lost result and no bubble cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_BAD   = 2'd3
  } elemSize_e;

  typedef struct packed {
    logic      load;
    elemSize_e size;
  } hzStrobe_t;

endpackage

// File: rtl/hz_control.sv
module hz_control
  import hz_pkg::*;
#(
  parameter int          OPC_W = 8,
  parameter logic [7:0]  OP_B  = 8'h68,
  parameter logic [7:0]  OP_W  = 8'h69,
  parameter logic [7:0]  OP_D  = 8'h6A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             outReady,
  input  logic [OPC_W-1:0] opCode,
  output logic             inReady,
  output logic             outValid,
  output logic             illegalOp,
  output hzStrobe_t        strobe
);

  elemSize_e decSize;
  logic      accept;

  always_comb begin
    if (opCode == OPC_W'(OP_B))      decSize = SZ_BYTE;
    else if (opCode == OPC_W'(OP_W)) decSize = SZ_WORD;
    else if (opCode == OPC_W'(OP_D)) decSize = SZ_DWORD;
    else                             decSize = SZ_BAD;
  end

  assign inReady = !outValid || outReady;
  assign accept  = inValid && inReady;

  assign strobe.load = accept;
  assign strobe.size = decSize;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else if (accept) begin
      outValid  <= 1'b1;
      illegalOp <= (decSize == SZ_BAD);
    end else if (outReady) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end
  end

endmodule

// File: rtl/hz_datapath.sv
module hz_datapath
  import hz_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  hzStrobe_t         strobe,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [DATA_W-1:0] srcOp,
  output logic [DATA_W-1:0] result
);

  localparam int HALF   = DATA_W / 2;
  localparam int NSIZES = 3;

  logic [NSIZES-1:0][DATA_W-1:0] zip;
  logic [DATA_W-1:0]             nextRes;
  logic                          unusedLowHalves;

  // Lower halves of both operands are deliberately dropped.
  assign unusedLowHalves = ^{dstOp[HALF-1:0], srcOp[HALF-1:0]};

  genvar gs, gi;
  generate
    for (gs = 0; gs < NSIZES; gs++) begin : g_size
      localparam int EW = 8 << gs;
      localparam int NE = HALF / EW;
      for (gi = 0; gi < NE; gi++) begin : g_elem
        // destination element in the lower slot of each pair
        assign zip[gs][2*gi*EW +: EW]     = dstOp[HALF + gi*EW +: EW];
        assign zip[gs][(2*gi+1)*EW +: EW] = srcOp[HALF + gi*EW +: EW];
      end
    end
  endgenerate

  always_comb begin
    case (strobe.size)
      SZ_BYTE:  nextRes = zip[0];
      SZ_WORD:  nextRes = zip[1];
      SZ_DWORD: nextRes = zip[2];
      default:  nextRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              result <= '0;
    else if (strobe.load) result <= nextRes;
  end

endmodule

// File: rtl/hiHalfZip.sv
module hiHalfZip
  import hz_pkg::*;
#(
  parameter int         DATA_W = 64,
  parameter int         OPC_W  = 8,
  parameter logic [7:0] OP_B   = 8'h68,
  parameter logic [7:0] OP_W   = 8'h69,
  parameter logic [7:0] OP_D   = 8'h6A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [DATA_W-1:0] srcOp,
  input  logic [OPC_W-1:0]  opCode,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] result,
  output logic              illegalOp
);

  hzStrobe_t strobe;

  hz_control #(
    .OPC_W(OPC_W), .OP_B(OP_B), .OP_W(OP_W), .OP_D(OP_D)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .opCode(opCode), .inReady(inReady), .outValid(outValid),
    .illegalOp(illegalOp), .strobe(strobe)
  );

  hz_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .dstOp(dstOp), .srcOp(srcOp), .result(result)
  );

endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int         DATA_W = 64,
  parameter int         OPC_W  = 8,
  parameter logic [7:0] OP_B   = 8'h68,
  parameter logic [7:0] OP_W   = 8'h69,
  parameter logic [7:0] OP_D   = 8'h6A
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] dstOp,
  input logic [DATA_W-1:0] srcOp,
  input logic [OPC_W-1:0]  opCode,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] result,
  input logic              illegalOp
);

  localparam int HALF = DATA_W / 2;

  logic accept;
  logic knownOp;
  assign accept  = inValid && inReady;
  assign knownOp = (opCode == OPC_W'(OP_B)) || (opCode == OPC_W'(OP_W)) ||
                   (opCode == OPC_W'(OP_D));

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> outValid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(result) && $stable(illegalOp)));

  p_stall_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |-> !inReady);

  p_illegal_flag_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> (illegalOp == !$past(knownOp)));

  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (outValid && illegalOp) |-> (result == '0));

  p_dword_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && opCode == OPC_W'(OP_D)) |=>
      (result == {$past(srcOp[DATA_W-1:HALF]), $past(dstOp[DATA_W-1:HALF])}));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!outValid && !illegalOp && result == '0));

endmodule

bind hiHalfZip hz_checker #(
  .DATA_W(DATA_W), .OPC_W(OPC_W), .OP_B(OP_B), .OP_W(OP_W), .OP_D(OP_D)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .dstOp(dstOp), .srcOp(srcOp), .opCode(opCode), .outValid(outValid),
  .outReady(outReady), .result(result), .illegalOp(illegalOp)
);

// File: tb/tb_hiHalfZip.sv
module tb_hiHalfZip;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic        inReady;
  logic [63:0] dstOp;
  logic [63:0] srcOp;
  logic [7:0]  opCode;
  logic        outValid;
  logic        outReady;
  logic [63:0] result;
  logic        illegalOp;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  hiHalfZip dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .dstOp(dstOp), .srcOp(srcOp), .opCode(opCode), .outValid(outValid),
    .outReady(outReady), .result(result), .illegalOp(illegalOp)
  );

  // {opcode, dst, src, expected, illegal}
  localparam int NVEC = 10;
  localparam logic [200:0] VEC [NVEC] = '{
    {8'h68, 64'h8877665544332211, 64'hFFEEDDCCBBAA9988, 64'hFF88EE77DD66CC55, 1'b0}, // R1
    {8'h69, 64'h8877665544332211, 64'hFFEEDDCCBBAA9988, 64'hFFEE8877DDCC6655, 1'b0}, // R2
    {8'h6A, 64'h8877665544332211, 64'hFFEEDDCCBBAA9988, 64'hFFEEDDCC88776655, 1'b0}, // R3
    {8'h68, 64'h8877665544332211, 64'h0000000000000000, 64'h0088007700660055, 1'b0}, // R5
    {8'h69, 64'h8877665544332211, 64'h0000000000000000, 64'h0000887700006655, 1'b0}, // R5
    {8'h6A, 64'h8877665544332211, 64'h0000000000000000, 64'h0000000088776655, 1'b0}, // R5
    {8'h68, 64'h0102030405060708, 64'h1112131415161718, 64'h1101120213031404, 1'b0}, // R4
    {8'h68, 64'h01020304AAAAAAAA, 64'h1112131455555555, 64'h1101120213031404, 1'b0}, // R4
    {8'h69, 64'h01020304FFFFFFFF, 64'h1112131400000000, 64'h1112010213140304, 1'b0}, // R4
    {8'h6B, 64'h8877665544332211, 64'hFFEEDDCCBBAA9988, 64'h0000000000000000, 1'b1}  // R6
  };

  function automatic logic [63:0] refZip(input logic [7:0] op,
                                         input logic [63:0] d,
                                         input logic [63:0] s);
    logic [63:0] r;
    r = '0;
    case (op)
      8'h68: for (int i = 0; i < 4; i++) begin
               r[16*i +: 8]   = d[32 + 8*i +: 8];
               r[16*i+8 +: 8] = s[32 + 8*i +: 8];
             end
      8'h69: for (int i = 0; i < 2; i++) begin
               r[32*i +: 16]    = d[32 + 16*i +: 16];
               r[32*i+16 +: 16] = s[32 + 16*i +: 16];
             end
      8'h6A: r = {s[63:32], d[63:32]};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // One operation with a ready consumer; sampled on the falling edge after acceptance.
  task automatic runOp(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                       input logic [63:0] expRes, input logic expIll, input string req);
    @(negedge clk);
    opCode = op; dstOp = d; srcOp = s; inValid = 1'b1; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, {req, " R7 outValid"}, 64'(outValid), 64'd1);
    check(result === expRes, {req, " result"}, result, expRes);
    check(illegalOp === expIll, {req, " R6 illegalOp"}, 64'(illegalOp), 64'(expIll));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finishRun();
  end

  initial begin
    logic [63:0] d, s, e;
    logic [7:0]  ops [3];
    ops[0] = 8'h68; ops[1] = 8'h69; ops[2] = 8'h6A;
    rst = 1'b1; inValid = 1'b0; outReady = 1'b0;
    dstOp = '0; srcOp = '0; opCode = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(outValid === 1'b0, "R9 outValid", 64'(outValid), 64'd0);
    check(illegalOp === 1'b0, "R9 illegalOp", 64'(illegalOp), 64'd0);
    check(result === 64'd0, "R9 result", result, 64'd0);
    check(inReady === 1'b1, "R9 inReady", 64'(inReady), 64'd1);
    rst = 1'b0;

    // Vector table: R1..R6
    for (int k = 0; k < NVEC; k++) begin
      runOp(VEC[k][200:193], VEC[k][192:129], VEC[k][128:65],
            VEC[k][64:1], VEC[k][0], $sformatf("R1-table row %0d", k));
    end

    // Random operands per mode and zero source (R1 R2 R3 R5)
    for (int m = 0; m < 3; m++) begin
      for (int n = 0; n < 20; n++) begin
        d = {$urandom, $urandom};
        s = (n % 4 == 0) ? 64'd0 : {$urandom, $urandom};
        runOp(ops[m], d, s, refZip(ops[m], d, s), 1'b0,
              (m == 0) ? "R1" : (m == 1) ? "R2" : "R3");
      end
    end

    // R6 random illegal opcodes
    for (int n = 0; n < 8; n++) begin
      logic [7:0] bad;
      bad = 8'($urandom);
      if (bad == 8'h68 || bad == 8'h69 || bad == 8'h6A) bad = 8'h00;
      runOp(bad, {$urandom, $urandom}, {$urandom, $urandom}, 64'd0, 1'b1, "R6");
    end

    // R8: back-pressure hold, then R10: drain and accept on the same edge
    @(negedge clk);
    d = 64'h8877665544332211; s = 64'hFFEEDDCCBBAA9988;
    opCode = 8'h68; dstOp = d; srcOp = s; inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    opCode = 8'h6A; dstOp = 64'hCAFEF00D12345678; srcOp = 64'h0BADBEEF9ABCDEF0;
    for (int c = 0; c < 3; c++) begin
      check(inReady === 1'b0, "R8 inReady", 64'(inReady), 64'd0);
      check(result === 64'hFF88EE77DD66CC55, "R8 held result", result, 64'hFF88EE77DD66CC55);
      check(outValid === 1'b1, "R8 outValid", 64'(outValid), 64'd1);
      @(negedge clk);
    end
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, "R10 outValid", 64'(outValid), 64'd1);
    check(result === 64'h0BADBEEFCAFEF00D, "R10 result", result, 64'h0BADBEEFCAFEF00D);
    @(negedge clk);
    check(outValid === 1'b0, "R10 drained", 64'(outValid), 64'd0);

    // R9: reset while an illegal result is held
    opCode = 8'hFF; inValid = 1'b1; outReady = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    check(illegalOp === 1'b1, "R6 held illegal", 64'(illegalOp), 64'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(outValid === 1'b0, "R9 mid reset outValid", 64'(outValid), 64'd0);
    check(illegalOp === 1'b0, "R9 mid reset illegalOp", 64'(illegalOp), 64'd0);
    check(inReady === 1'b1, "R9 mid reset inReady", 64'(inReady), 64'd1);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule